// File: doc/BRIEF.md
# Bidirectional Latched Bus Transceiver

This block sits between two tri-state data buses, called A and B. Each direction of flow has its own bank of level-sensitive latches. One bank carries data from A towards B and the other carries data from B towards A. A bank is transparent while it is selected and open, so its contents follow the source bus. It keeps the value it had when it closes.

Each direction has three active-low controls. The select input gates everything in that direction: no loading and no driving happen while it is high. The open input makes the selected bank transparent, and its rising edge closes the bank. The drive input turns on the output buffers towards the opposite bus. Data is never inverted. The two directions share no state and no control.

The latches have no reset. A user loads each bank transparently before relying on what it holds. There is no clock, so the model is purely combinational plus latches and can be synthesized.

Top module: `latched_bus_xcvr`

## Requirements
- R1: While `ab_sel_n`=0 and `ab_open_n`=0, the A-to-B bank follows bus A. With `ab_drive_n`=0, bus B then shows the A value bit for bit, without inversion.
- R2: A rising edge on `ab_open_n` while `ab_sel_n`=0 keeps the A value present just before the edge. After that, bus B does not follow later changes on A.
- R3: While `ab_sel_n`=1, the block releases bus B to high impedance, whatever the value of `ab_drive_n`.
- R4: While `ab_drive_n`=1, the block releases bus B to high impedance, whatever the value of `ab_sel_n`.
- R5: While a direction's select input is 1, that direction's bank keeps its contents, whatever its open input and its source bus do.
- R6: While `ba_sel_n`=0 and `ba_open_n`=0, the B-to-A bank follows bus B. With `ba_drive_n`=0, bus A then shows the B value without inversion.
- R7: A rising edge on `ba_open_n` while `ba_sel_n`=0 keeps the B value present just before the edge. After that, bus A does not follow later changes on B.
- R8: The block releases bus A to high impedance unless both `ba_sel_n` and `ba_drive_n` are 0.
- R9: The B-to-A controls and activity on bus B leave the A-to-B bank and its B output unchanged, and the same holds with the two directions swapped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_io | inout | WIDTH | Bus A: source for the A-to-B bank, driven by the B-to-A bank |
| b_io | inout | WIDTH | Bus B: source for the B-to-A bank, driven by the A-to-B bank |
| ab_sel_n | input | 1 | A-to-B select, active low; gates loading and driving |
| ab_open_n | input | 1 | A-to-B bank transparent when low; rising edge captures |
| ab_drive_n | input | 1 | A-to-B output enable onto bus B, active low |
| ba_sel_n | input | 1 | B-to-A select, active low; gates loading and driving |
| ba_open_n | input | 1 | B-to-A bank transparent when low; rising edge captures |
| ba_drive_n | input | 1 | B-to-A output enable onto bus A, active low |

## Verification
The assertions assume that no bank is transparent while its own source bus is driven by the opposite bank. That case would form a combinational loop through both banks, and its value is not defined. They also assume the buses settle within one time step. The random stimulus keeps within this: whenever it makes a bank transparent, it turns off the opposite direction's drive. It releases its own bus driver before a control change lets the block drive that bus. The bench places a pull-up on each bus, so a released bus with no other driver reads as all ones. It keeps held data distinct from that value in the directed cases.

// File: rtl/xcvr_pkg.sv
// Shared types for the latched bus transceiver.
// Assumes all controls are active low and that the two directions share no state.
package xcvr_pkg;

    // Raw active-low controls of one flow direction
    typedef struct packed {
        logic sel_n;
        logic open_n;
        logic drive_n;
    } dir_ctrl_t;

    // Decoded actions of one flow direction
    typedef struct packed {
        logic load;
        logic drive;
    } dir_act_t;

endpackage

// File: rtl/xcvr_dir_decode.sv
// Turns one direction's active-low controls into load and drive actions.
// Assumes the select input gates both actions; no clock, no reset.
module xcvr_dir_decode
    import xcvr_pkg::*;
(
    input  dir_ctrl_t ctrl,
    output dir_act_t  act
);

    // Decode: the select must be low before either action may happen
    always_comb begin
        act.load  = !ctrl.sel_n && !ctrl.open_n;
        act.drive = !ctrl.sel_n && !ctrl.drive_n;
    end

endmodule

// File: rtl/xcvr_latch_bank.sv
// A bank of WIDTH level-sensitive latches, transparent while load is high.
// Assumes the source is stable around the falling edge of load; no reset.
module xcvr_latch_bank #(
    parameter int WIDTH = 8
) (
    input  logic             load,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    // Storage: follow d while open, keep the last value once closed
    always_latch begin
        if (load) q <= d;
    end

endmodule

// File: rtl/xcvr_path.sv
// One flow direction: control decode followed by its latch bank.
// Assumes the caller attaches the tri-state buffer using the drive output.
module xcvr_path
    import xcvr_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  dir_ctrl_t        ctrl,
    input  logic [WIDTH-1:0] src,
    output logic [WIDTH-1:0] held,
    output logic             drive
);

    dir_act_t act;

    xcvr_dir_decode u_dec (
        .ctrl (ctrl),
        .act  (act)
    );

    xcvr_latch_bank #(.WIDTH(WIDTH)) u_bank (
        .load (act.load),
        .d    (src),
        .q    (held)
    );

    // Export the drive action for the bus buffer
    assign drive = act.drive;

endmodule

// File: rtl/latched_bus_xcvr.sv
// Bidirectional latched transceiver between tri-state buses A and B.
// Each direction has its own latch bank and its own active-low controls.
// Assumes no bank is transparent while its source bus is driven by the
// opposite bank. There is no clock and no reset; banks power up undefined.
module latched_bus_xcvr
    import xcvr_pkg::*;
#(
    parameter int WIDTH = 8
) (
    inout  wire  [WIDTH-1:0] a_io,
    inout  wire  [WIDTH-1:0] b_io,
    input  logic             ab_sel_n,
    input  logic             ab_open_n,
    input  logic             ab_drive_n,
    input  logic             ba_sel_n,
    input  logic             ba_open_n,
    input  logic             ba_drive_n
);

    localparam logic [WIDTH-1:0] RELEASED = {WIDTH{1'bz}};

    dir_ctrl_t        ab_ctrl, ba_ctrl;
    logic [WIDTH-1:0] ab_held, ba_held;
    logic             ab_drv, ba_drv;

    // Gather the raw controls of each direction
    always_comb begin
        ab_ctrl = '{sel_n: ab_sel_n, open_n: ab_open_n, drive_n: ab_drive_n};
        ba_ctrl = '{sel_n: ba_sel_n, open_n: ba_open_n, drive_n: ba_drive_n};
    end

    xcvr_path #(.WIDTH(WIDTH)) u_a2b (
        .ctrl  (ab_ctrl),
        .src   (a_io),
        .held  (ab_held),
        .drive (ab_drv)
    );

    xcvr_path #(.WIDTH(WIDTH)) u_b2a (
        .ctrl  (ba_ctrl),
        .src   (b_io),
        .held  (ba_held),
        .drive (ba_drv)
    );

    // Tri-state output buffers, non-inverting
    assign b_io = ab_drv ? ab_held : RELEASED;
    assign a_io = ba_drv ? ba_held : RELEASED;

    // Checks across the decode, the bank and the port controls
    always_comb begin
        // R1
        ab_follow_chk: assert (!(!ab_sel_n && !ab_open_n) || ab_held == a_io)
            else $error("A-to-B bank not following bus A while open");
        // R3 R4
        ab_release_chk: assert (!ab_drv || (!ab_sel_n && !ab_drive_n))
            else $error("bus B driven without select and drive low");
        // R6
        ba_follow_chk: assert (!(!ba_sel_n && !ba_open_n) || ba_held == b_io)
            else $error("B-to-A bank not following bus B while open");
        // R8
        ba_release_chk: assert (!ba_drv || (!ba_sel_n && !ba_drive_n))
            else $error("bus A driven without select and drive low");
    end

endmodule

// File: tb/tb_latched_bus_xcvr.sv
module tb_latched_bus_xcvr;
    localparam int CLK_PERIOD = 10;
    localparam int W = 8;
    localparam logic [W-1:0] PULLED = {W{1'b1}};

    logic clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    wire  [W-1:0] a_io, b_io;
    logic [W-1:0] a_val = '0, b_val = '0;
    logic         a_en = 1'b0, b_en = 1'b0;
    logic ab_sel_n = 1'b1, ab_open_n = 1'b1, ab_drive_n = 1'b1;
    logic ba_sel_n = 1'b1, ba_open_n = 1'b1, ba_drive_n = 1'b1;

    assign a_io = a_en ? a_val : {W{1'bz}};
    assign b_io = b_en ? b_val : {W{1'bz}};
    for (genvar i = 0; i < W; i++) begin : g_pull
        pullup (a_io[i]);
        pullup (b_io[i]);
    end

    latched_bus_xcvr #(.WIDTH(W)) dut (
        .a_io(a_io), .b_io(b_io),
        .ab_sel_n(ab_sel_n), .ab_open_n(ab_open_n), .ab_drive_n(ab_drive_n),
        .ba_sel_n(ba_sel_n), .ba_open_n(ba_open_n), .ba_drive_n(ba_drive_n)
    );

    int tests = 0, fails = 0;
    logic [W-1:0] m_ab = '0, m_ba = '0;

    function automatic logic [W-1:0] bus_expect(logic dut_drv, logic [W-1:0] held,
                                                logic tb_drv, logic [W-1:0] tb_v);
        if (dut_drv) return held;
        if (tb_drv)  return tb_v;
        return PULLED;
    endfunction

    function automatic logic ab_drives(logic s, logic d); return !s && !d; endfunction

    task automatic chk(string tag, logic [W-1:0] act, logic [W-1:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Model update from the current settled inputs
    task automatic model_update();
        logic [W-1:0] a_in, b_in;
        a_in = bus_expect(ab_drives(ba_sel_n, ba_drive_n), m_ba, a_en, a_val);
        b_in = bus_expect(ab_drives(ab_sel_n, ab_drive_n), m_ab, b_en, b_val);
        if (!ab_sel_n && !ab_open_n) m_ab = a_in;
        if (!ba_sel_n && !ba_open_n) m_ba = b_in;
    endtask

    // Two phases: controls first (old data), then new bus data
    task automatic apply(logic [5:0] c, logic na_en, logic [W-1:0] na,
                         logic nb_en, logic [W-1:0] nb);
        @(posedge clk);
        {ab_sel_n, ab_open_n, ab_drive_n, ba_sel_n, ba_open_n, ba_drive_n} = c;
        if (ab_drives(ba_sel_n, ba_drive_n)) a_en = 1'b0;
        if (ab_drives(ab_sel_n, ab_drive_n)) b_en = 1'b0;
        @(negedge clk);
        model_update();
        @(posedge clk);
        a_en = na_en; a_val = na; b_en = nb_en; b_val = nb;
        @(negedge clk);
        model_update();
        // contention flag: bench and block both driving one bus
        if ((a_en && ab_drives(ba_sel_n, ba_drive_n)) ||
            (b_en && ab_drives(ab_sel_n, ab_drive_n))) begin
            tests++; fails++;
            $display("FAIL contention: actual 1 expected 0");
        end
    endtask

    task automatic chk_bus(string tag_b, string tag_a);
        chk(tag_b, b_io, bus_expect(ab_drives(ab_sel_n, ab_drive_n), m_ab, b_en, b_val));
        chk(tag_a, a_io, bus_expect(ab_drives(ba_sel_n, ba_drive_n), m_ba, a_en, a_val));
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        tests++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin : main
        void'($urandom(32'h5eed1234));
        // Initial state: everything released, both buses pulled high
        @(negedge clk);
        chk("R3 idle B", b_io, PULLED);
        chk("R8 idle A", a_io, PULLED);

        // R1: transparent A-to-B, B follows A
        apply(6'b000_111, 1'b1, 8'h5A, 1'b0, 8'h00);
        chk("R1 B shows A", b_io, 8'h5A);
        apply(6'b000_111, 1'b1, 8'hC3, 1'b0, 8'h00);
        chk("R1 B follows A", b_io, 8'hC3);
        // R2: close, then change A
        apply(6'b010_111, 1'b1, 8'hC3, 1'b0, 8'h00);
        apply(6'b010_111, 1'b1, 8'h0F, 1'b0, 8'h00);
        chk("R2 B holds", b_io, 8'hC3);
        // R4: drive off releases B
        apply(6'b011_111, 1'b1, 8'h0F, 1'b0, 8'h00);
        chk("R4 B released", b_io, PULLED);
        // R3: select off releases B even with drive low
        apply(6'b100_111, 1'b1, 8'h0F, 1'b0, 8'h00);
        chk("R3 B released", b_io, PULLED);
        // R5: select high, open toggles and A changes: content kept
        apply(6'b110_111, 1'b1, 8'h77, 1'b0, 8'h00);
        apply(6'b100_111, 1'b1, 8'h12, 1'b0, 8'h00);
        apply(6'b110_111, 1'b1, 8'h34, 1'b0, 8'h00);
        apply(6'b010_111, 1'b1, 8'h34, 1'b0, 8'h00);
        chk("R5 A-to-B held", b_io, 8'hC3);

        // R6: transparent B-to-A
        apply(6'b111_000, 1'b0, 8'h00, 1'b1, 8'hA5);
        chk("R6 A shows B", a_io, 8'hA5);
        // R7: close, change B
        apply(6'b111_010, 1'b0, 8'h00, 1'b1, 8'hA5);
        apply(6'b111_010, 1'b0, 8'h00, 1'b1, 8'h3C);
        chk("R7 A holds", a_io, 8'hA5);
        // R8: drive off and select off release A
        apply(6'b111_011, 1'b0, 8'h00, 1'b1, 8'h3C);
        chk("R8 A released drive", a_io, PULLED);
        apply(6'b111_100, 1'b0, 8'h00, 1'b1, 8'h3C);
        chk("R8 A released sel", a_io, PULLED);
        // R5 for B-to-A: select high, open low, B changes
        apply(6'b111_101, 1'b0, 8'h00, 1'b1, 8'h66);
        apply(6'b111_010, 1'b0, 8'h00, 1'b1, 8'h66);
        chk("R5 B-to-A held", a_io, 8'hA5);

        // R9: B-to-A activity leaves A-to-B content alone
        apply(6'b011_000, 1'b0, 8'h00, 1'b1, 8'h99);
        apply(6'b011_010, 1'b0, 8'h00, 1'b1, 8'h44);
        apply(6'b010_111, 1'b1, 8'h21, 1'b0, 8'h00);
        chk("R9 A-to-B untouched", b_io, 8'hC3);
        apply(6'b111_010, 1'b0, 8'h00, 1'b1, 8'h21);
        chk("R9 B-to-A kept own", a_io, 8'h99);

        // Random phase, with the loop-free constraint
        for (int n = 0; n < 400; n++) begin
            logic [5:0] c;
            logic ae, be;
            c = 6'($urandom);
            if (!c[5] && !c[4] && !c[2] && !c[0]) c[0] = 1'b1;
            if (!c[2] && !c[1] && !c[5] && !c[3]) c[3] = 1'b1;
            ae = ($urandom % 5) != 0;
            be = ($urandom % 5) != 0;
            if (!c[2] && !c[0]) ae = 1'b0;
            if (!c[5] && !c[3]) be = 1'b0;
            apply(c, ae, W'($urandom), be, W'($urandom));
            if (ab_drives(ab_sel_n, ab_drive_n))
                chk(ab_open_n ? "R2 B random" : "R1 B random", b_io, m_ab);
            else
                chk(ab_sel_n ? "R3 B random" : "R4 B random", b_io,
                    bus_expect(1'b0, m_ab, b_en, b_val));
            if (ab_drives(ba_sel_n, ba_drive_n))
                chk(ba_open_n ? "R7 A random" : "R6 A random", a_io, m_ba);
            else
                chk("R8 A random", a_io, bus_expect(1'b0, m_ba, a_en, a_val));
        end

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule